// File: doc/BRIEF.md
# Register Map Address Decoder

This block turns one CPU access into per-register select strobes for a small memory-mapped register block. It takes a request valid that the bus front end has already masked, a byte offset and a write flag. It raises the single strobe that belongs to the addressed register, or to the addressed slice of it. It also raises a flag when the access must be served outside the block. The decoder is purely combinational, so the strobes follow the inputs within the same cycle.

The address is a byte offset from the base of the register map, compared at the full address width. The access width is 32 bits. The example map holds the following items:

- a plain 32-bit control register at 0x00;
- a 64-bit register at 0x08, read and written as two 32-bit halves;
- a 2×2 register array starting at 0x10;
- an externally served read-only register at 0x20;
- an externally served write-only register at 0x24;
- an external window covering 0x40 to 0x5F.

Two field-level strobes are derived from the halves of the 64-bit register. Field A covers bits 16 to 47, so it straddles both halves. Field B covers bits 40 to 63, so it lies in the upper half only.

Top module: `regmap_addr_decode`

## Requirements
- R1: `sel_ctrl` is 1 only when `req_i` is 1 and `addr_i` is 0x00.
- R2: `sel_wide[k]` is 1 only when `req_i` is 1 and `addr_i` equals 0x08 + 4·k, for k = 0 or 1. Bit 0 is the low word.
- R3: Array element [r][c] sits at 0x10 + 8·r + 4·c. The 8-byte outer stride is the 4-byte inner stride times the inner size of 2. Its strobe is bit 2·r + c of `sel_arr`, and it is 1 only for a request at that address.
- R4: `sel_win` is 1 for a request at any address from 0x40 to 0x5F inclusive, and 0 at 0x3F and at 0x60. Whenever it is 1, `is_external` is 1 for both reads and writes.
- R5: `sel_ext_ro` is 1 for any request at 0x20. For that address, `is_external` is 1 only when `is_wr_i` is 0.
- R6: `sel_ext_wo` is 1 for any request at 0x24. For that address, `is_external` is 1 only when `is_wr_i` is 1.
- R7: `sel_fld_a` (bits 16..47 of the 64-bit register) is the OR of both half strobes. It is 1 at 0x08 and at 0x0C.
- R8: `sel_fld_b` (bits 40..63) follows the upper half strobe alone. It is 1 at 0x0C and 0 at 0x08.
- R9: When `req_i` is 0, every strobe and `is_external` are 0 for every address and direction.
- R10: An address outside every item listed above raises no strobe and leaves `is_external` at 0. At most one register or window strobe is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_i | input | 1 | Masked request valid |
| addr_i | input | ADDR_W (8) | Byte offset from the map base |
| is_wr_i | input | 1 | 1 for a write, 0 for a read |
| sel_ctrl | output | 1 | Control register strobe |
| sel_wide | output | 2 | Per-half strobes of the 64-bit register |
| sel_arr | output | 4 | Array element strobes, index 2·r + c |
| sel_ext_ro | output | 1 | External read-only register strobe |
| sel_ext_wo | output | 1 | External write-only register strobe |
| sel_win | output | 1 | External window strobe |
| sel_fld_a | output | 1 | Strobe of the field that straddles both halves |
| sel_fld_b | output | 1 | Strobe of the field in the upper half |
| is_external | output | 1 | Access is served outside the block |

## Verification
The bench sweeps all 256 offsets for reads and writes, with and without a request. This covers each window edge: a decoder with an off-by-one limit would claim 0x3F or 0x60, or would lose 0x5F. It also covers the array corners: an outer stride computed without the inner size would alias rows [1][0] and [0][1]. The direction cases at 0x20 and 0x24 expose an `is_external` that ignores the access direction. The two field strobes expose a reduction that looks only at the low half, or that ORs in a half the field never touches.

// File: rtl/regmap_addr_decode.sv
module regmap_addr_decode #(
  parameter int ADDR_W     = 8,
  parameter int ACC_W      = 32,
  parameter int WIDE_W     = 64,
  parameter int CTRL_OFF   = 'h00,
  parameter int WIDE_OFF   = 'h08,
  parameter int ARR_OFF    = 'h10,
  parameter int ARR_ROWS   = 2,
  parameter int ARR_COLS   = 2,
  parameter int ARR_STRIDE = 4,
  parameter int RO_OFF     = 'h20,
  parameter int WO_OFF     = 'h24,
  parameter int WIN_OFF    = 'h40,
  parameter int WIN_SIZE   = 'h20,
  parameter int FA_LSB     = 16,
  parameter int FA_MSB     = 47,
  parameter int FB_LSB     = 40,
  parameter int FB_MSB     = 63
) (
  input  logic                         req_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic                         is_wr_i,
  output logic                         sel_ctrl,
  output logic [WIDE_W/ACC_W-1:0]      sel_wide,
  output logic [ARR_ROWS*ARR_COLS-1:0] sel_arr,
  output logic                         sel_ext_ro,
  output logic                         sel_ext_wo,
  output logic                         sel_win,
  output logic                         sel_fld_a,
  output logic                         sel_fld_b,
  output logic                         is_external
);
  localparam int SUBW      = WIDE_W / ACC_W;
  localparam int ACC_BYTES = ACC_W / 8;
  localparam int ROW_STEP  = ARR_STRIDE * ARR_COLS;
  localparam int WIN_LAST  = WIN_OFF + WIN_SIZE - 1;

  function automatic logic [SUBW-1:0] span_mask(input int lsb, input int msb);
    logic [SUBW-1:0] m;
    m = '0;
    for (int k = 0; k < SUBW; k++)
      m[k] = (k >= lsb / ACC_W) && (k <= msb / ACC_W);
    return m;
  endfunction

  localparam logic [SUBW-1:0] FA_MASK = span_mask(FA_LSB, FA_MSB);
  localparam logic [SUBW-1:0] FB_MASK = span_mask(FB_LSB, FB_MSB);

  logic [ADDR_W:0] addr_x;
  assign addr_x = {1'b0, addr_i};

  assign sel_ctrl = req_i && (addr_i == ADDR_W'(CTRL_OFF));

  for (genvar k = 0; k < SUBW; k++) begin : g_sub
    assign sel_wide[k] = req_i && (addr_i == ADDR_W'(WIDE_OFF + k * ACC_BYTES));
  end

  for (genvar r = 0; r < ARR_ROWS; r++) begin : g_row
    for (genvar c = 0; c < ARR_COLS; c++) begin : g_col
      assign sel_arr[r*ARR_COLS + c] =
        req_i && (addr_i == ADDR_W'(ARR_OFF + r * ROW_STEP + c * ARR_STRIDE));
    end
  end

  assign sel_ext_ro = req_i && (addr_i == ADDR_W'(RO_OFF));
  assign sel_ext_wo = req_i && (addr_i == ADDR_W'(WO_OFF));
  assign sel_win    = req_i && (addr_x >= (ADDR_W+1)'(WIN_OFF))
                            && (addr_x <= (ADDR_W+1)'(WIN_LAST));

  assign sel_fld_a = |(sel_wide & FA_MASK);
  assign sel_fld_b = |(sel_wide & FB_MASK);

  assign is_external = sel_win
                     || (sel_ext_ro && !is_wr_i)
                     || (sel_ext_wo && is_wr_i);
endmodule

// File: rtl/regmap_addr_decode_chk.sv
module regmap_addr_decode_chk (
  input logic       req_i,
  input logic       is_wr_i,
  input logic       sel_ctrl,
  input logic [1:0] sel_wide,
  input logic [3:0] sel_arr,
  input logic       sel_ext_ro,
  input logic       sel_ext_wo,
  input logic       sel_win,
  input logic       sel_fld_a,
  input logic       sel_fld_b,
  input logic       is_external
);
  always_comb begin
    if (!req_i)
      a_r9_idle_quiet: assert ({sel_ctrl, sel_wide, sel_arr, sel_ext_ro, sel_ext_wo,
                                sel_win, sel_fld_a, sel_fld_b, is_external} == '0);
    a_r10_single_hit: assert ($onehot0({sel_ctrl, sel_wide, sel_arr, sel_ext_ro,
                                        sel_ext_wo, sel_win}));
    if (sel_win)
      a_r4_window_external: assert (is_external);
    if (sel_ext_ro && is_wr_i)
      a_r5_ro_write_internal: assert (!is_external);
    if (sel_ext_wo && !is_wr_i)
      a_r6_wo_read_internal: assert (!is_external);
    if (sel_fld_b)
      a_r8_upper_in_span: assert (sel_fld_a && sel_wide[1]);
    if (sel_fld_a)
      a_r7_span_from_halves: assert (|sel_wide);
  end
endmodule

bind regmap_addr_decode regmap_addr_decode_chk u_chk (
  .req_i(req_i), .is_wr_i(is_wr_i), .sel_ctrl(sel_ctrl), .sel_wide(sel_wide),
  .sel_arr(sel_arr), .sel_ext_ro(sel_ext_ro), .sel_ext_wo(sel_ext_wo),
  .sel_win(sel_win), .sel_fld_a(sel_fld_a), .sel_fld_b(sel_fld_b),
  .is_external(is_external)
);

// File: tb/regmap_addr_decode_tb.sv
module regmap_addr_decode_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic       req_i, is_wr_i;
  logic [7:0] addr_i;
  logic       sel_ctrl, sel_ext_ro, sel_ext_wo, sel_win, sel_fld_a, sel_fld_b, is_external;
  logic [1:0] sel_wide;
  logic [3:0] sel_arr;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  regmap_addr_decode u_dut (
    .req_i(req_i), .addr_i(addr_i), .is_wr_i(is_wr_i),
    .sel_ctrl(sel_ctrl), .sel_wide(sel_wide), .sel_arr(sel_arr),
    .sel_ext_ro(sel_ext_ro), .sel_ext_wo(sel_ext_wo), .sel_win(sel_win),
    .sel_fld_a(sel_fld_a), .sel_fld_b(sel_fld_b), .is_external(is_external)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%02h req=%0b wr=%0b actual=%04h expected=%04h",
               tag, addr_i, req_i, is_wr_i, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    req_i = 1'b0; is_wr_i = 1'b0; addr_i = 8'h00;
    @(negedge clk);
    check("R9 idle", {5'b0, sel_ctrl, sel_wide, sel_arr, sel_ext_ro, sel_ext_wo,
                      sel_win, is_external}, 16'h0);
    for (int r = 0; r < 2; r++) begin
      for (int w = 0; w < 2; w++) begin
        for (int a = 0; a < 256; a++) begin
          logic       e_ctrl, e_ro, e_wo, e_win, e_ext, e_fa, e_fb;
          logic [1:0] e_wide;
          logic [3:0] e_arr;
          string      tag;
          @(posedge clk);
          req_i = r[0]; is_wr_i = w[0]; addr_i = a[7:0];
          e_ctrl = r[0] && a == 0;
          for (int k = 0; k < 2; k++) e_wide[k] = r[0] && a == 8 + 4*k;
          for (int i = 0; i < 2; i++)
            for (int j = 0; j < 2; j++) e_arr[i*2+j] = r[0] && a == 16 + 8*i + 4*j;
          e_ro  = r[0] && a == 'h20;
          e_wo  = r[0] && a == 'h24;
          e_win = r[0] && a >= 'h40 && a <= 'h5F;
          e_ext = e_win || (e_ro && !w[0]) || (e_wo && w[0]);
          e_fa  = e_wide[0] || e_wide[1];
          e_fb  = e_wide[1];
          if (!r[0])            tag = "R9";
          else if (a == 0)      tag = "R1";
          else if (|e_wide)     tag = "R2";
          else if (|e_arr)      tag = "R3";
          else if (e_win)       tag = "R4";
          else if (e_ro)        tag = "R5";
          else if (e_wo)        tag = "R6";
          else                  tag = "R10";
          @(negedge clk);
          check(tag, {5'b0, sel_ctrl, sel_wide, sel_arr, sel_ext_ro, sel_ext_wo,
                      sel_win, is_external},
                {5'b0, e_ctrl, e_wide, e_arr, e_ro, e_wo, e_win, e_ext});
          check(e_fb ? "R8 field" : "R7 field", {14'b0, sel_fld_a, sel_fld_b},
                {14'b0, e_fa, e_fb});
        end
      end
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule